// File: doc/BRIEF.md
# Variable-length instruction decoder

This block turns the raw bytes at the program counter into the fields an execution stage needs. Each cycle it may be handed a six-byte window fetched at the current PC, together with that PC. The first byte carries an instruction class in its upper four bits and an operation selector in its lower four bits. From that byte alone the decoder works out how many bytes the instruction occupies (1, 2, 5 or 6). It then picks the two register identifiers out of the register byte when there is one. It also gathers a 32-bit little-endian constant, which serves as a displacement, an immediate or an absolute branch target.

The results appear one clock after the window is presented, all registered together. They are the class, the selector, both register identifiers, the constant, the length, the address of the following instruction and a flag for encodings that are not defined. Register identifier 8 stands for "no register". The decoder drives it on both register outputs whenever the instruction carries no register byte. Fetching, the register file and execution sit outside this block.

Top module: `insn_decoder`

## Requirements
- R1: For a defined encoding, the length output is 1 for class 0 (no-op) and class 1 (halt). It is 2 for class 2 (register copy) and class 6 (arithmetic/logic). It is 5 for class 7 (branch), and 6 for class 3 (immediate load), class 4 (store to memory) and class 5 (load from memory).
- R2: The class output equals bits [7:4] of window byte 0 and the selector output equals bits [3:0] of window byte 0. Window byte k sits at `win_i[8k+7:8k]`.
- R3: When the instruction has a register byte (classes 2 to 6), `reg_a_o` is bits [7:4] of byte 1 and `reg_b_o` is bits [3:0] of byte 1. Otherwise both outputs are 8.
- R4: For classes 3, 4 and 5 the constant is bytes 2 to 5 taken least significant first, so byte 2 lands in bits [7:0].
- R5: For class 7 the constant is bytes 1 to 4 taken least significant first, with no register byte in between.
- R6: For classes 0, 1, 2 and 6, and for every undefined encoding, the constant output is zero.
- R7: `next_pc_o` equals the presented PC plus the decoded length, modulo 2^32.
- R8: The undefined flag is set when the class is above 7, or when the selector is nonzero for classes 0 to 5, above 3 for class 6, or above 6 for class 7. An undefined encoding reports length 1, registers 8 and 8, and constant 0.
- R9: `dec_valid_o` is high exactly one cycle after a cycle with `win_valid_i` high. While reset is asserted, `dec_valid_o` and every other output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid_i | input | 1 | Window and PC are meaningful this cycle |
| pc_i | input | 32 | Address of window byte 0 |
| win_i | input | 48 | Fetched bytes, byte k at bits [8k+7:8k] |
| dec_valid_o | output | 1 | Decoded fields are present |
| icls_o | output | 4 | Instruction class |
| isel_o | output | 4 | Operation selector |
| reg_a_o | output | 4 | First register identifier, 8 if none |
| reg_b_o | output | 4 | Second register identifier, 8 if none |
| const_o | output | 32 | Assembled little-endian constant |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | PC of the following instruction |
| undef_o | output | 1 | Encoding is not defined |

## Verification
The assertions assume that `win_valid_i` and `pc_i` are driven to known values from the first clock onward and are sampled only at rising edges. The PC check also depends on the previous cycle's PC and valid being meaningful once reset has been released. The bench changes every input a short time after each rising edge and holds it stable until the next one, and it keeps `win_valid_i` low through reset. It mixes back-to-back windows with idle gaps, so the one-cycle pairing of input and result is exercised both ways.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int LEN_W      = 3;
    localparam int CONST_B    = 4;
    localparam int CONST_W    = CONST_B * BYTE_W;
    localparam logic [NIB_W-1:0] REG_NONE = 4'h8;

    typedef enum logic [NIB_W-1:0] {
        CLS_NOP   = 4'h0,
        CLS_HALT  = 4'h1,
        CLS_RRMV  = 4'h2,
        CLS_IRMV  = 4'h3,
        CLS_STORE = 4'h4,
        CLS_LOAD  = 4'h5,
        CLS_ALU   = 4'h6,
        CLS_JUMP  = 4'h7
    } cls_e;

    // where the constant starts inside the window
    typedef enum logic [1:0] {
        CPOS_NONE  = 2'd0,
        CPOS_BYTE1 = 2'd1,
        CPOS_BYTE2 = 2'd2
    } cpos_e;

    localparam logic [NIB_W-1:0] ALU_SEL_MAX  = 4'h3;
    localparam logic [NIB_W-1:0] JUMP_SEL_MAX = 4'h6;

    typedef struct packed {
        logic                 valid;
        logic [NIB_W-1:0]     cls;
        logic [NIB_W-1:0]     sel;
        logic [NIB_W-1:0]     ra;
        logic [NIB_W-1:0]     rb;
        logic [CONST_W-1:0]   cval;
        logic [LEN_W-1:0]     len;
        logic                 undef;
    } dec_t;

endpackage

// File: rtl/ivd_shape.sv
module ivd_shape
    import ivd_pkg::*;
(
    input  logic [NIB_W-1:0] cls_i,
    output logic [LEN_W-1:0] len_o,
    output logic             has_regs_o,
    output cpos_e            cpos_o
);
    always_comb begin
        len_o      = LEN_W'(1);
        has_regs_o = 1'b0;
        cpos_o     = CPOS_NONE;
        case (cls_i)
            CLS_NOP, CLS_HALT: begin
                len_o = LEN_W'(1);
            end
            CLS_RRMV, CLS_ALU: begin
                len_o      = LEN_W'(2);
                has_regs_o = 1'b1;
            end
            CLS_IRMV, CLS_STORE, CLS_LOAD: begin
                len_o      = LEN_W'(6);
                has_regs_o = 1'b1;
                cpos_o     = CPOS_BYTE2;
            end
            CLS_JUMP: begin
                len_o  = LEN_W'(5);
                cpos_o = CPOS_BYTE1;
            end
            default: begin
                len_o = LEN_W'(1);
            end
        endcase
    end
endmodule

// File: rtl/ivd_legal.sv
module ivd_legal
    import ivd_pkg::*;
(
    input  logic [NIB_W-1:0] cls_i,
    input  logic [NIB_W-1:0] sel_i,
    output logic             ok_o
);
    always_comb begin
        case (cls_i)
            CLS_NOP, CLS_HALT, CLS_RRMV, CLS_IRMV, CLS_STORE, CLS_LOAD:
                ok_o = (sel_i == '0);
            CLS_ALU:  ok_o = (sel_i <= ALU_SEL_MAX);
            CLS_JUMP: ok_o = (sel_i <= JUMP_SEL_MAX);
            default:  ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ivd_fields.sv
module ivd_fields
    import ivd_pkg::*;
#(
    parameter int WIN_BYTES = 6
) (
    input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
    input  logic                        has_regs_i,
    input  cpos_e                       cpos_i,
    output logic [NIB_W-1:0]            ra_o,
    output logic [NIB_W-1:0]            rb_o,
    output logic [CONST_W-1:0]          cval_o
);
    localparam int REG_BYTE = 1;

    logic [BYTE_W-1:0] reg_byte;
    assign reg_byte = win_i[REG_BYTE*BYTE_W +: BYTE_W];
    assign ra_o = has_regs_i ? reg_byte[BYTE_W-1 -: NIB_W] : REG_NONE;
    assign rb_o = has_regs_i ? reg_byte[NIB_W-1:0]         : REG_NONE;

    // one lane per constant byte, picking from either start offset
    for (genvar b = 0; b < CONST_B; b++) begin : g_lane
        logic [BYTE_W-1:0] from_b1;
        logic [BYTE_W-1:0] from_b2;
        assign from_b1 = win_i[(b + 1) * BYTE_W +: BYTE_W];
        assign from_b2 = win_i[(b + 2) * BYTE_W +: BYTE_W];
        always_comb begin
            case (cpos_i)
                CPOS_BYTE1: cval_o[b*BYTE_W +: BYTE_W] = from_b1;
                CPOS_BYTE2: cval_o[b*BYTE_W +: BYTE_W] = from_b2;
                default:    cval_o[b*BYTE_W +: BYTE_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import ivd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        win_valid_i,
    input  logic [ADDR_W-1:0]           pc_i,
    input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
    output logic                        dec_valid_o,
    output logic [NIB_W-1:0]            icls_o,
    output logic [NIB_W-1:0]            isel_o,
    output logic [NIB_W-1:0]            reg_a_o,
    output logic [NIB_W-1:0]            reg_b_o,
    output logic [CONST_W-1:0]          const_o,
    output logic [LEN_W-1:0]            len_o,
    output logic [ADDR_W-1:0]           next_pc_o,
    output logic                        undef_o
);
    localparam int WIN_W = WIN_BYTES * BYTE_W;

    logic [NIB_W-1:0]   cls_w, sel_w;
    logic [LEN_W-1:0]   shape_len;
    logic               shape_regs;
    cpos_e              shape_cpos;
    logic               legal;
    logic               use_regs;
    cpos_e              use_cpos;
    logic [NIB_W-1:0]   f_ra, f_rb;
    logic [CONST_W-1:0] f_cval;

    dec_t              dec_d, dec_q;
    logic [ADDR_W-1:0] npc_d, npc_q;

    assign cls_w = win_i[BYTE_W-1 -: NIB_W];
    assign sel_w = win_i[NIB_W-1:0];

    ivd_shape u_shape (
        .cls_i      (cls_w),
        .len_o      (shape_len),
        .has_regs_o (shape_regs),
        .cpos_o     (shape_cpos)
    );

    ivd_legal u_legal (
        .cls_i (cls_w),
        .sel_i (sel_w),
        .ok_o  (legal)
    );

    // undefined encodings behave like a bare one-byte instruction
    assign use_regs = shape_regs & legal;
    assign use_cpos = legal ? shape_cpos : CPOS_NONE;

    ivd_fields #(.WIN_BYTES(WIN_BYTES)) u_fields (
        .win_i      (win_i[WIN_W-1:0]),
        .has_regs_i (use_regs),
        .cpos_i     (use_cpos),
        .ra_o       (f_ra),
        .rb_o       (f_rb),
        .cval_o     (f_cval)
    );

    always_comb begin
        dec_d       = dec_q;
        npc_d       = npc_q;
        dec_d.valid = win_valid_i;
        if (win_valid_i) begin
            dec_d.cls   = cls_w;
            dec_d.sel   = sel_w;
            dec_d.ra    = f_ra;
            dec_d.rb    = f_rb;
            dec_d.cval  = f_cval;
            dec_d.len   = legal ? shape_len : LEN_W'(1);
            dec_d.undef = ~legal;
            npc_d       = pc_i + ADDR_W'(dec_d.len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
            npc_q <= '0;
        end else begin
            dec_q <= dec_d;
            npc_q <= npc_d;
        end
    end

    assign dec_valid_o = dec_q.valid;
    assign icls_o      = dec_q.cls;
    assign isel_o      = dec_q.sel;
    assign reg_a_o     = dec_q.ra;
    assign reg_b_o     = dec_q.rb;
    assign const_o     = dec_q.cval;
    assign len_o       = dec_q.len;
    assign next_pc_o   = npc_q;
    assign undef_o     = dec_q.undef;

    // R9: a result follows each accepted window by one cycle
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_i |=> dec_valid_o);

    // R1: only the four legal lengths ever appear
    a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (len_o == 3'd1 || len_o == 3'd2 || len_o == 3'd5 || len_o == 3'd6));

    // R3: instructions without a register byte report no registers
    a_r3_no_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && (len_o == 3'd1 || len_o == 3'd5)) |-> (reg_a_o == REG_NONE && reg_b_o == REG_NONE));

    // R6: short instructions carry no constant
    a_r6_const_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && len_o <= 3'd2) |-> (const_o == '0));

    // R8: an undefined encoding collapses to one byte
    a_r8_undef_len: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && undef_o) |-> (len_o == 3'd1));

    // R7: next PC relates to the PC presented a cycle earlier
    a_r7_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_i ##1 dec_valid_o) |-> (next_pc_o == $past(pc_i) + ADDR_W'(len_o)));

endmodule

// File: tb/insn_decoder_test.sv
module insn_decoder_test;

    typedef struct {
        logic [3:0]  cls, sel, ra, rb;
        logic [31:0] cval, npc;
        logic [2:0]  len;
        logic        undef;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [47:0] win_i = '0;
    logic        dec_valid_o;
    logic [3:0]  icls_o, isel_o, reg_a_o, reg_b_o;
    logic [31:0] const_o, next_pc_o;
    logic [2:0]  len_o;
    logic        undef_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic exp_v  = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    insn_decoder uut (
        .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid_i), .pc_i(pc_i), .win_i(win_i),
        .dec_valid_o(dec_valid_o), .icls_o(icls_o), .isel_o(isel_o),
        .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .const_o(const_o), .len_o(len_o),
        .next_pc_o(next_pc_o), .undef_o(undef_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // model built from the requirements; m holds bytes in memory order, first byte leftmost
    function automatic exp_t model(input logic [31:0] pc, input logic [47:0] m);
        exp_t e;
        logic [7:0] b [6];
        logic ok;
        for (int k = 0; k < 6; k++) b[k] = m[47 - 8*k -: 8];
        e.cls = b[0][7:4];
        e.sel = b[0][3:0];
        if (e.cls == 4'd6)      ok = (e.sel <= 4'd3);
        else if (e.cls == 4'd7) ok = (e.sel <= 4'd6);
        else if (e.cls <= 4'd5) ok = (e.sel == 4'd0);
        else                    ok = 1'b0;
        e.undef = !ok;
        if (!ok)                                   e.len = 3'd1;
        else if (e.cls <= 4'd1)                    e.len = 3'd1;
        else if (e.cls == 4'd2 || e.cls == 4'd6)   e.len = 3'd2;
        else if (e.cls == 4'd7)                    e.len = 3'd5;
        else                                       e.len = 3'd6;
        if (e.len == 3'd2 || e.len == 3'd6) begin
            e.ra = b[1][7:4];
            e.rb = b[1][3:0];
        end else begin
            e.ra = 4'd8;
            e.rb = 4'd8;
        end
        if (e.len == 3'd6)      e.cval = {b[5], b[4], b[3], b[2]};
        else if (e.len == 3'd5) e.cval = {b[4], b[3], b[2], b[1]};
        else                    e.cval = 32'd0;
        e.npc = pc + 32'(e.len);
        return e;
    endfunction

    task automatic send(input logic [31:0] pc, input logic [47:0] m);
        @(posedge clk);
        #2;
        win_valid_i = 1'b1;
        pc_i = pc;
        for (int k = 0; k < 6; k++) win_i[8*k +: 8] = m[47 - 8*k -: 8];
        sb.push_back(model(pc, m));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            win_valid_i = 1'b0;
            win_i = 48'hffff_ffff_ffff;
        end
    endtask

    always @(posedge clk) exp_v <= rst_n ? win_valid_i : 1'b0;

    // monitor: compare each produced result with the oldest expectation
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", "valid timing", 32'(dec_valid_o), 32'(exp_v));
            if (dec_valid_o && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk("R2", "class", 32'(icls_o), 32'(e.cls));
                chk("R2", "selector", 32'(isel_o), 32'(e.sel));
                chk("R1", "length", 32'(len_o), 32'(e.len));
                chk("R3", "reg_a", 32'(reg_a_o), 32'(e.ra));
                chk("R3", "reg_b", 32'(reg_b_o), 32'(e.rb));
                chk(e.len == 3'd6 ? "R4" : (e.len == 3'd5 ? "R5" : "R6"), "constant", const_o, e.cval);
                chk("R7", "next pc", next_pc_o, e.npc);
                chk("R8", "undefined flag", 32'(undef_o), 32'(e.undef));
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset valid", 32'(dec_valid_o), 32'd0);
        chk("R9", "reset length", 32'(len_o), 32'd0);
        chk("R9", "reset next pc", next_pc_o, 32'd0);
        chk("R9", "reset constant", const_o, 32'd0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        send(32'h0000_0100, 48'h00_ff_ff_ff_ff_ff);   // no-op, R1 R3
        send(32'h0000_0101, 48'h10_12_34_56_78_9a);   // halt
        send(32'h0000_0200, 48'h20_43_aa_bb_cc_dd);   // register copy, R6
        send(32'h0000_0202, 48'h30_82_cd_ab_00_00);   // immediate load, R4
        send(32'h0000_0208, 48'h40_64_1c_04_00_00);   // store, R4
        idle(2);
        send(32'h0000_0300, 48'h50_15_f4_ff_ff_ff);   // load with negative displacement
        send(32'h0000_0306, 48'h60_06_11_22_33_44);   // add
        send(32'h0000_0308, 48'h63_71_00_00_00_00);   // xor, top ALU selector
        send(32'h0000_0057, 48'h74_57_00_00_00_ee);   // branch, R5
        send(32'h0000_0400, 48'h76_78_56_34_12_99);   // branch, top selector
        idle(1);
        send(32'h0000_0500, 48'h80_12_34_56_78_9a);   // R8 class above 7
        send(32'h0000_0501, 48'hf3_12_34_56_78_9a);   // R8 class 15
        send(32'h0000_0502, 48'h27_43_00_00_00_00);   // R8 nonzero selector
        send(32'h0000_0503, 48'h64_06_00_00_00_00);   // R8 ALU selector 4
        send(32'h0000_0504, 48'h77_57_00_00_00_00);   // R8 branch selector 7
        send(32'h0000_0505, 48'h11_00_00_00_00_00);   // R8 halt with selector 1
        send(32'hffff_fffe, 48'h30_87_78_56_34_12);   // R7 wrap
        send(32'hffff_fffd, 48'h71_ff_ff_ff_7f_00);   // R7 wrap on branch
        idle(3);
        chk("R9", "queue drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule